// File: doc/BRIEF.md
# Dual-Strobe Asynchronous DRAM Cycle Decoder

This block sits on the device side of an asynchronous DRAM interface that has one row strobe and two column strobes, one for each byte. The strobes, write enable and output enable are all active low. A fast system clock samples them. Each memory cycle is sorted into a class by the order in which the strobe edges arrive. For every cycle the block produces an output-enable and a write strobe for each byte lane, and a refresh row address.

The two column strobes are merged into one internal column strobe. It turns active on the first lane to fall and inactive on the last lane to rise. The merged strobe is what decides the cycle class. Each lane strobe still gates its own byte: the low-lane strobe gates bits 0 to 7 and the high-lane strobe gates bits 8 to 15. The block is meant as a front end for a DRAM emulator or a protocol checker. It holds no storage array and models no analog output timing.

Every strobe passes through a two-flop synchronizer. A cycle class is reported on `cycClass` together with a one-clock `classValid` pulse. It is reported in the clock where the deciding edge is seen after synchronization.

Top module: `dram_strobe_decoder`

## Requirements
- R1: The merged column strobe is active while either lane strobe is low. One column access with staggered lane falls gives exactly one class report. Raising only the first lane keeps the access open, and the other lane keeps driving.
- R2: `loOe` is high only while the low-lane strobe, OE and RAS-side access allow a read, with WE high. `hiOe` works the same way from the high-lane strobe. A lane whose strobe is high never drives.
- R3: If the column strobe is low when the row strobe falls, the cycle is a counter refresh, class 5. `refRow` takes the internal counter value whatever the address input holds, and both output enables stay low.
- R4: After reset the refresh counter is 0. It advances by one after each counter refresh (class 5 or 6) and wraps from 1023 to 0.
- R5: A row strobe low period with no column access is a row-only refresh, class 4. It is reported when the row strobe rises, with `refRow` equal to the address sampled when the row strobe fell. Output enables stay low.
- R6: If WE is already low when the column strobe falls, the cycle is an early write, class 2. The block gives one write pulse on each lane whose strobe is low, and no output enable.
- R7: If WE falls while a read access (class 1) is open, the cycle becomes a late write, class 3. Data is driven before WE falls. After WE falls, a write pulse goes to each active lane and the output enables drop.
- R8: If the row strobe rises and falls again while the column strobe stays low after an access, the cycle is a hidden refresh, class 6. It uses the counter row, and the read output stays enabled throughout.
- R9: Once the row and column strobes have both been high for two sampled clocks, `cycClass` reads 0 (standby) and no lane drives.
- R10: After reset, `cycClass` is 0, and `classValid`, the write pulses and the output enables are all low.
- R11: A column fall with WE high inside an open row is a read, class 1. It is reported once, whether one lane or both lanes are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rasN | input | 1 | Row strobe, active low |
| lcasN | input | 1 | Low byte column strobe, active low |
| ucasN | input | 1 | High byte column strobe, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | AddrW | Multiplexed address, sampled as row at row strobe fall |
| loOe | output | 1 | Drive enable for bits 0..7 |
| hiOe | output | 1 | Drive enable for bits 8..15 |
| loWr | output | 1 | One-clock write pulse for bits 0..7 |
| hiWr | output | 1 | One-clock write pulse for bits 8..15 |
| classValid | output | 1 | One-clock pulse when a cycle class is decided |
| cycClass | output | 3 | Class: 0 standby, 1 read, 2 early write, 3 late write, 4 row-only refresh, 5 counter refresh, 6 hidden refresh |
| refRow | output | AddrW | Row refreshed by the last refresh class |

## Verification
The properties assume that every strobe level is held for at least two sampling clocks, so that no edge is lost in the synchronizer. They also assume that the address is stable while the row strobe falls. Finally, they assume that the row and column strobes never change in the same sampled clock in a way that mixes two cycle kinds. The directed stimulus changes one strobe at a time and waits four clocks before the next change. It holds the address for the whole row-strobe low period. This keeps every edge order unambiguous.

// File: rtl/dram_dec_pkg.sv
package dram_dec_pkg;

  typedef enum logic [2:0] {
    CLS_STANDBY  = 3'd0,
    CLS_READ     = 3'd1,
    CLS_EARLY_WR = 3'd2,
    CLS_LATE_WR  = 3'd3,
    CLS_RAS_ONLY = 3'd4,
    CLS_CBR      = 3'd5,
    CLS_HIDDEN   = 3'd6
  } cyc_cls_e;

  typedef struct packed {
    logic     decide;
    cyc_cls_e cls;
    logic     latchRow;
    logic     useCounter;
    logic     wrPulse;
    logic     drvEn;
    logic     idleNow;
  } dec_strobe_t;

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int          W       = 5,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stg[0] <= RST_VAL;
    else       stg[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stg[i] <= RST_VAL;
      else       stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/dram_dec_ctrl.sv
module dram_dec_ctrl
  import dram_dec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rasAct,
  input  logic        casAct,
  input  logic        weAct,
  output dec_strobe_t strb
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_CASWAIT, ST_ROWOPEN, ST_RD, ST_WR, ST_HOLD, ST_HIDDEN, ST_CBR
  } st_e;

  st_e  st, stNxt;
  logic accessed, accNxt;
  logic weActD;
  logic weFall;

  assign weFall = weAct & ~weActD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      accessed <= 1'b0;
      weActD   <= 1'b0;
    end else begin
      st       <= stNxt;
      accessed <= accNxt;
      weActD   <= weAct;
    end
  end

  always_comb begin
    stNxt = st;
    accNxt = accessed;
    strb = '0;
    strb.cls = CLS_STANDBY;
    strb.idleNow = !rasAct && !casAct;
    strb.drvEn = (st == ST_RD) || (st == ST_HOLD) || (st == ST_HIDDEN);
    case (st)
      ST_IDLE, ST_CASWAIT: begin
        if (rasAct && casAct) begin
          stNxt = ST_CBR;
          strb.decide = 1'b1;
          strb.cls = CLS_CBR;
          strb.useCounter = 1'b1;
        end else if (rasAct) begin
          stNxt = ST_ROWOPEN;
          strb.latchRow = 1'b1;
          accNxt = 1'b0;
        end else if (casAct) begin
          stNxt = ST_CASWAIT;
        end else begin
          stNxt = ST_IDLE;
        end
      end
      ST_ROWOPEN: begin
        if (!rasAct) begin
          stNxt = casAct ? ST_CASWAIT : ST_IDLE;
          if (!accessed) begin
            strb.decide = 1'b1;
            strb.cls = CLS_RAS_ONLY;
          end
        end else if (casAct) begin
          accNxt = 1'b1;
          strb.decide = 1'b1;
          if (weAct) begin
            stNxt = ST_WR;
            strb.cls = CLS_EARLY_WR;
            strb.wrPulse = 1'b1;
          end else begin
            stNxt = ST_RD;
            strb.cls = CLS_READ;
          end
        end
      end
      ST_RD: begin
        if (!casAct) stNxt = rasAct ? ST_ROWOPEN : ST_IDLE;
        else if (!rasAct) stNxt = ST_HOLD;
        else if (weFall) begin
          stNxt = ST_WR;
          strb.decide = 1'b1;
          strb.cls = CLS_LATE_WR;
          strb.wrPulse = 1'b1;
        end
      end
      ST_WR: begin
        if (!casAct) stNxt = rasAct ? ST_ROWOPEN : ST_IDLE;
        else if (!rasAct) stNxt = ST_HOLD;
      end
      ST_HOLD: begin
        if (!casAct) begin
          stNxt = rasAct ? ST_ROWOPEN : ST_IDLE;
          if (rasAct) begin
            strb.latchRow = 1'b1;
            accNxt = 1'b0;
          end
        end else if (rasAct) begin
          stNxt = ST_HIDDEN;
          strb.decide = 1'b1;
          strb.cls = CLS_HIDDEN;
          strb.useCounter = 1'b1;
        end
      end
      ST_HIDDEN: begin
        if (!rasAct) stNxt = casAct ? ST_HOLD : ST_IDLE;
        else if (!casAct) stNxt = ST_CBR;
      end
      ST_CBR: begin
        if (!rasAct) stNxt = casAct ? ST_CASWAIT : ST_IDLE;
      end
      default: stNxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/dram_dec_datapath.sv
module dram_dec_datapath
  import dram_dec_pkg::*;
#(
  parameter int AddrW = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  dec_strobe_t      strb,
  input  logic [AddrW-1:0] addr,
  input  logic             lcAct,
  input  logic             ucAct,
  input  logic             oeAct,
  input  logic             weAct,
  output logic             loOe,
  output logic             hiOe,
  output logic             loWr,
  output logic             hiWr,
  output logic             classValid,
  output logic [2:0]       cycClass,
  output logic [AddrW-1:0] refRow
);

  logic [AddrW-1:0] rowLatch;
  logic [AddrW-1:0] refreshCnt;
  cyc_cls_e         clsReg;
  logic             readPath;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowLatch   <= '0;
      refreshCnt <= '0;
      refRow     <= '0;
      clsReg     <= CLS_STANDBY;
      classValid <= 1'b0;
      loWr       <= 1'b0;
      hiWr       <= 1'b0;
    end else begin
      if (strb.latchRow) rowLatch <= addr;
      if (strb.decide && strb.useCounter) begin
        refRow     <= refreshCnt;
        refreshCnt <= refreshCnt + 1'b1;
      end else if (strb.decide && strb.cls == CLS_RAS_ONLY) begin
        refRow <= rowLatch;
      end
      if (strb.decide)       clsReg <= strb.cls;
      else if (strb.idleNow) clsReg <= CLS_STANDBY;
      classValid <= strb.decide;
      loWr <= strb.wrPulse & lcAct;
      hiWr <= strb.wrPulse & ucAct;
    end
  end

  assign readPath = strb.drvEn & oeAct & ~weAct;
  assign loOe     = readPath & lcAct;
  assign hiOe     = readPath & ucAct;
  assign cycClass = clsReg;

endmodule

// File: rtl/dram_strobe_decoder.sv
module dram_strobe_decoder
  import dram_dec_pkg::*;
#(
  parameter int AddrW      = 10,
  parameter int SyncStages = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rasN,
  input  logic             lcasN,
  input  logic             ucasN,
  input  logic             weN,
  input  logic             oeN,
  input  logic [AddrW-1:0] addr,
  output logic             loOe,
  output logic             hiOe,
  output logic             loWr,
  output logic             hiWr,
  output logic             classValid,
  output logic [2:0]       cycClass,
  output logic [AddrW-1:0] refRow
);

  localparam int NumStrobes = 5;

  logic [NumStrobes-1:0] rawN, syncN;
  logic rasAct, lcAct, ucAct, weAct, oeAct, casAct;
  dec_strobe_t strb;

  assign rawN = {rasN, lcasN, ucasN, weN, oeN};

  strobe_sync #(.W(NumStrobes), .STAGES(SyncStages), .RST_VAL('1)) i_sync (
    .clk(clk), .rstN(rstN), .din(rawN), .dout(syncN)
  );

  assign {rasAct, lcAct, ucAct, weAct, oeAct} = ~syncN;
  assign casAct = lcAct | ucAct;

  dram_dec_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .rasAct(rasAct), .casAct(casAct),
    .weAct(weAct), .strb(strb)
  );

  dram_dec_datapath #(.AddrW(AddrW)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr),
    .lcAct(lcAct), .ucAct(ucAct), .oeAct(oeAct), .weAct(weAct),
    .loOe(loOe), .hiOe(hiOe), .loWr(loWr), .hiWr(hiWr),
    .classValid(classValid), .cycClass(cycClass), .refRow(refRow)
  );

endmodule

// File: rtl/dram_strobe_decoder_chk.sv
module dram_strobe_decoder_chk #(
  parameter int AddrW = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             rasAct,
  input logic             casAct,
  input logic             loOe,
  input logic             hiOe,
  input logic             loWr,
  input logic             hiWr,
  input logic             classValid,
  input logic [2:0]       cycClass,
  input logic [AddrW-1:0] refRow
);

  logic [AddrW-1:0] expRow;
  logic             cntRef;

  assign cntRef = classValid && (cycClass == 3'd5 || cycClass == 3'd6);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       expRow <= '0;
    else if (cntRef) expRow <= expRow + 1'b1;
  end

  // R4
  cnt_row_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntRef |-> refRow == expRow);

  // R3
  cbr_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (classValid && cycClass == 3'd5) |-> (!loOe && !hiOe));

  // R6
  wr_pulse_class_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loWr || hiWr) |-> (classValid && (cycClass == 3'd2 || cycClass == 3'd3)));

  // R7
  wr_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loWr || hiWr) |-> (!loOe && !hiOe));

  // R9
  standby_class_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rasAct && !casAct && $past(!rasAct && !casAct)) |=> cycClass == 3'd0);

endmodule

bind dram_strobe_decoder dram_strobe_decoder_chk #(.AddrW(AddrW)) i_chk (
  .clk(clk), .rstN(rstN), .rasAct(rasAct), .casAct(casAct),
  .loOe(loOe), .hiOe(hiOe), .loWr(loWr), .hiWr(hiWr),
  .classValid(classValid), .cycClass(cycClass), .refRow(refRow)
);

// File: tb/test_dram_strobe_decoder.sv
module test_dram_strobe_decoder;

  localparam int AddrW = 10;
  localparam int RowMod = 1 << AddrW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rasN = 1'b1, lcasN = 1'b1, ucasN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [AddrW-1:0] addr = '0;
  logic loOe, hiOe, loWr, hiWr, classValid;
  logic [2:0] cycClass;
  logic [AddrW-1:0] refRow;

  int errors = 0;
  int checks = 0;
  int nValid = 0, nLoWr = 0, nHiWr = 0;
  int lastCls = 0, lastRow = 0;
  int expCnt = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dram_strobe_decoder #(.AddrW(AddrW)) i_dram_strobe_decoder (
    .clk(clk), .rstN(rstN), .rasN(rasN), .lcasN(lcasN), .ucasN(ucasN),
    .weN(weN), .oeN(oeN), .addr(addr), .loOe(loOe), .hiOe(hiOe),
    .loWr(loWr), .hiWr(hiWr), .classValid(classValid),
    .cycClass(cycClass), .refRow(refRow)
  );

  always @(negedge clk) begin
    if (classValid) begin
      nValid++;
      lastCls = int'(cycClass);
      lastRow = int'(refRow);
    end
    if (loWr) nLoWr++;
    if (hiWr) nHiWr++;
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic t_reset;
    chk("R10 class after reset", int'(cycClass), 0);
    chk("R10 valid after reset", int'(classValid), 0);
    chk("R10 oe after reset", int'({loOe, hiOe}), 0);
    chk("R10 wr after reset", int'({loWr, hiWr}), 0);
  endtask

  task automatic t_ras_only(logic [AddrW-1:0] row);
    int v0 = nValid;
    addr = row; step(1);
    rasN = 1'b0; step(4);
    addr = ~row; oeN = 1'b0;
    chk("R5 no drive in row-only", int'({loOe, hiOe}), 0);
    rasN = 1'b1; step(4);
    oeN = 1'b1;
    chk("R5 one report", nValid - v0, 1);
    chk("R5 class", lastCls, 4);
    chk("R5 row", lastRow, int'(row));
  endtask

  task automatic t_read(bit lo, bit hi);
    int v0 = nValid;
    addr = 10'h155; rasN = 1'b0; step(4);
    weN = 1'b1; oeN = 1'b0;
    if (lo) lcasN = 1'b0;
    step(2);
    if (hi) ucasN = 1'b0;
    step(4);
    chk("R11 one read report", nValid - v0, 1);
    chk("R11 read class", lastCls, 1);
    chk("R2 low lane drive", int'(loOe), int'(lo));
    chk("R2 high lane drive", int'(hiOe), int'(hi));
    if (lo && hi) begin
      lcasN = 1'b1; step(4);
      chk("R1 access open after first rise", int'(hiOe), 1);
      chk("R1 released lane idle", int'(loOe), 0);
      chk("R1 no extra report", nValid - v0, 1);
    end
    lcasN = 1'b1; ucasN = 1'b1; step(4);
    chk("R2 drive off after column rise", int'({loOe, hiOe}), 0);
    rasN = 1'b1; oeN = 1'b1; step(5);
    chk("R9 standby class", int'(cycClass), 0);
    chk("R9 no row-only after access", nValid - v0, 1);
  endtask

  task automatic t_early_write(bit lo, bit hi);
    int v0 = nValid, l0 = nLoWr, h0 = nHiWr;
    weN = 1'b0; oeN = 1'b0; rasN = 1'b0; step(4);
    lcasN = !lo; ucasN = !hi; step(4);
    chk("R6 early class", lastCls, 2);
    chk("R6 one report", nValid - v0, 1);
    chk("R6 low pulses", nLoWr - l0, int'(lo));
    chk("R6 high pulses", nHiWr - h0, int'(hi));
    chk("R6 no drive", int'({loOe, hiOe}), 0);
    lcasN = 1'b1; ucasN = 1'b1; step(3);
    rasN = 1'b1; weN = 1'b1; oeN = 1'b1; step(4);
  endtask

  task automatic t_late_write;
    int v0 = nValid, l0 = nLoWr, h0 = nHiWr;
    weN = 1'b1; oeN = 1'b0; rasN = 1'b0; step(4);
    lcasN = 1'b0; ucasN = 1'b0; step(4);
    chk("R7 data driven first", int'({loOe, hiOe}), 3);
    chk("R7 read first", lastCls, 1);
    weN = 1'b0; step(4);
    chk("R7 late class", lastCls, 3);
    chk("R7 two reports", nValid - v0, 2);
    chk("R7 both lanes pulsed", (nLoWr - l0) + (nHiWr - h0), 2);
    chk("R7 drive off after write", int'({loOe, hiOe}), 0);
    lcasN = 1'b1; ucasN = 1'b1; step(3);
    rasN = 1'b1; weN = 1'b1; oeN = 1'b1; step(4);
  endtask

  task automatic t_cbr;
    weN = 1'b1; oeN = 1'b0; ucasN = 1'b0; step(4);
    addr = 10'h3a7; rasN = 1'b0; step(4);
    chk("R3 counter refresh class", lastCls, 5);
    chk("R3 counter row", lastRow, expCnt);
    chk("R3 no drive", int'({loOe, hiOe}), 0);
    expCnt = (expCnt + 1) % RowMod;
    rasN = 1'b1; step(3);
    ucasN = 1'b1; oeN = 1'b1; step(4);
  endtask

  task automatic t_hidden;
    weN = 1'b1; oeN = 1'b0; rasN = 1'b0; step(4);
    lcasN = 1'b0; step(4);
    rasN = 1'b1; step(4);
    chk("R8 held drive after row rise", int'(loOe), 1);
    rasN = 1'b0; step(4);
    chk("R8 hidden class", lastCls, 6);
    chk("R8 counter row", lastRow, expCnt);
    chk("R8 drive held in refresh", int'(loOe), 1);
    expCnt = (expCnt + 1) % RowMod;
    rasN = 1'b1; step(3);
    lcasN = 1'b1; oeN = 1'b1; step(4);
  endtask

  task automatic t_wrap;
    int bad = 0;
    int startCnt = expCnt;
    lcasN = 1'b0; step(4);
    for (int i = 0; i < RowMod; i++) begin
      rasN = 1'b0; step(4);
      if (lastRow != expCnt || lastCls != 5) bad++;
      expCnt = (expCnt + 1) % RowMod;
      rasN = 1'b1; step(3);
    end
    chk("R4 counter sequence mismatches", bad, 0);
    rasN = 1'b0; step(4);
    chk("R4 wrapped to start", lastRow, (startCnt + RowMod) % RowMod);
    expCnt = (expCnt + 1) % RowMod;
    rasN = 1'b1; step(3);
    lcasN = 1'b1; step(4);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step(4);
    t_reset();
    t_ras_only(10'h2c1);
    t_read(1'b1, 1'b1);
    t_read(1'b1, 1'b0);
    t_read(1'b0, 1'b1);
    t_early_write(1'b1, 1'b1);
    t_early_write(1'b0, 1'b1);
    t_late_write();
    t_cbr();
    t_hidden();
    t_cbr();
    t_wrap();
    t_ras_only(10'h013);
    summary();
  end

endmodule